// File: doc/BRIEF.md
# Carry Bypass Adder

A combinational two's-complement adder of parameterised width that splits its operands into equal groups of full adders. Inside each group the carry ripples bit by bit. Every group also has a skip multiplexer. When every bit position of the group propagates, meaning the two operand bits differ everywhere, the multiplexer passes the group's carry-in straight to its carry-out. In any other case the group's carry-out does not depend on its carry-in, so it is taken from the ripple chain.

Each bit is classified as propagate, generate or delete from its two operand bits. This classification is ready before any carry arrives. The sum bits of a group always come from the rippled internal carries, using the carry-in that the group actually received. The block is dropped into a datapath wherever a plain add of two operands plus a carry-in is needed. The default is 16 bits in four groups of four. The group size may be set anywhere from 4 to 8 bits, as long as it divides the width.

Top module: `carry_bypass_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of the unsigned total `a + b + cin`, for any operands.
- R2: `cout` equals bit WIDTH of the unsigned total `a + b + cin`.
- R3: When `b` is the bitwise inverse of `a`, every group bypasses. With `cin` = 1 the result is `sum` = 0 and `cout` = 1. With `cin` = 0 the result is `sum` = all ones and `cout` = 0.
- R4: If both operand bits at the most significant position are 1, `cout` is 1 for either value of `cin`. If both are 0, `cout` is 0 for either value of `cin`.
- R5: A carry produced in the lowest group reaches `cout` through upper groups that all propagate. For example, 0xA5AF + 0x5A51 with `cin` = 0 gives `sum` = 0 and `cout` = 1.
- R6: Zero operands with `cin` = 0 give `sum` = 0 and `cout` = 0. With `cin` = 1 they give `sum` = 1 and `cout` = 0.
- R7: All-ones operands with `cin` = 1 give `sum` = all ones and `cout` = 1.
- R8: With the group size set to 8 instead of 4, the results are identical to those of R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Some properties are checked by the assertions on every input change. Each bit must fall into exactly one of the propagate, generate and delete classes. A group that bypasses must produce the same carry as its own ripple chain would. A generating or deleting top bit must force the group carry-out. The full result must equal an arithmetic addition, and complementary operands must hand `cin` through to `cout`.

Other behaviours can only be shown by the bench's scenarios: a carry crossing several bypassed groups in a row, both values of `cin` applied to the same operands, the extreme operand values, and agreement between the 4-bit and 8-bit group builds.

// File: rtl/cba_pkg.sv
package cba_pkg;

  // Classification of one bit position before the carry arrives.
  typedef struct packed {
    logic p;  // operand bits differ: carry passes through
    logic g;  // both bits set: carry created
    logic d;  // both bits clear: carry killed
  } bit_class_t;

  function automatic bit_class_t classify(input logic a, input logic b);
    bit_class_t c;
    c.p = a ^ b;
    c.g = a & b;
    c.d = ~a & ~b;
    return c;
  endfunction

  function automatic logic sum_of(input bit_class_t c, input logic ci);
    return c.p ^ ci;
  endfunction

  function automatic logic carry_of(input bit_class_t c, input logic ci);
    return c.g | (c.p & ci);
  endfunction

endpackage

// File: rtl/cba_bit_cell.sv
module cba_bit_cell
  import cba_pkg::*;
(
  input  logic       a,
  input  logic       b,
  output bit_class_t cls
);

  assign cls = classify(a, b);

  // R1: each bit falls into exactly one class
  always_comb begin
    p_class_onehot_r1: assert ($countones({cls.p, cls.g, cls.d}) == 1)
      else $error("bit class not one-hot");
  end

endmodule

// File: rtl/cba_group.sv
module cba_group
  import cba_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          ci,
  output logic [GW-1:0] s,
  output logic          co
);

  bit_class_t      cls [GW];
  logic [GW:0]     chain;
  logic [GW-1:0]   prop_vec;
  logic            skip_sel;
  logic            ripple_co;

  assign chain[0] = ci;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    cba_bit_cell u_cell (
      .a   (a[i]),
      .b   (b[i]),
      .cls (cls[i])
    );
    assign prop_vec[i]  = cls[i].p;
    assign s[i]         = sum_of(cls[i], chain[i]);
    assign chain[i+1]   = carry_of(cls[i], chain[i]);
  end

  assign ripple_co = chain[GW];
  assign skip_sel  = &prop_vec;
  assign co        = skip_sel ? ci : ripple_co;

  always_comb begin
    // R3: bypass path and ripple path agree when the group fully propagates
    if (skip_sel)
      p_bypass_agrees_r3: assert (ripple_co == ci)
        else $error("bypass differs from ripple");
    // R4: a generating top bit forces the group carry high
    if (cls[GW-1].g)
      p_top_generate_r4: assert (co == 1'b1)
        else $error("generate at top did not set carry");
    // R4: a deleting top bit forces the group carry low
    if (cls[GW-1].d)
      p_top_delete_r4: assert (co == 1'b0)
        else $error("delete at top did not clear carry");
  end

endmodule

// File: rtl/carry_bypass_adder.sv
module carry_bypass_adder
  import cba_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int unsigned NGROUPS = WIDTH / GROUP;

  if ((WIDTH % GROUP) != 0 || GROUP < 4 || GROUP > 8) begin : g_bad_cfg
    $error("GROUP must lie in 4..8 and divide WIDTH");
  end

  logic [NGROUPS:0] grp_carry;

  assign grp_carry[0] = cin;

  for (genvar k = 0; k < NGROUPS; k++) begin : g_grp
    cba_group #(.GW(GROUP)) u_grp (
      .a  (a[k*GROUP +: GROUP]),
      .b  (b[k*GROUP +: GROUP]),
      .ci (grp_carry[k]),
      .s  (sum[k*GROUP +: GROUP]),
      .co (grp_carry[k+1])
    );
  end

  assign cout = grp_carry[NGROUPS];

  logic [WIDTH:0] arith_total;
  assign arith_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    // R1 R2: structural result matches arithmetic addition
    p_sum_matches_r1: assert ({cout, sum} == arith_total)
      else $error("structural sum differs from arithmetic");
    // R3: complementary operands hand the carry-in straight out
    if (b == ~a)
      p_full_propagate_r3: assert (cout == cin && sum == {WIDTH{~cin}})
        else $error("full propagate result wrong");
  end

endmodule

// File: tb/tb_carry_bypass_adder.sv
module tb_carry_bypass_adder;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum, sum8;
  logic         cout, cout8;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  carry_bypass_adder #(.WIDTH(W), .GROUP(4)) dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  carry_bypass_adder #(.WIDTH(W), .GROUP(8)) dut_g8 (
    .a(a), .b(b), .cin(cin), .sum(sum8), .cout(cout8)
  );

  task automatic check_val(input string req, input logic [W-1:0] act,
                           input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply a vector, then compare with a behavioural total half a cycle later.
  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_v,
                       input logic tc, input string req);
    longint unsigned tot;
    @(posedge clk);
    a = ta; b = tb_v; cin = tc;
    @(negedge clk);
    tot = longint'(ta) + longint'(tb_v) + longint'(tc);
    check_val({req, " sum R1"}, sum, W'(tot));
    check_val({req, " cout R2"}, W'(cout), W'(tot >> W));
    check_val({req, " g8 sum R8"}, sum8, W'(tot));
    check_val({req, " g8 cout R8"}, W'(cout8), W'(tot >> W));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    check_val("reset-state R6", sum, '0);

    // R6: zero operands
    apply('0, '0, 1'b0, "zero R6");
    check_val("zero cout R6", W'(cout), '0);
    apply('0, '0, 1'b1, "zero cin R6");
    check_val("zero cin sum R6", sum, W'(1));

    // R7: all ones
    apply('1, '1, 1'b1, "ones R7");
    check_val("ones sum R7", sum, '1);
    check_val("ones cout R7", W'(cout), W'(1));

    // R3: full propagate in every group
    apply(16'h3C96, ~16'h3C96, 1'b1, "allprop cin1 R3");
    check_val("allprop cin1 sum R3", sum, '0);
    check_val("allprop cin1 cout R3", W'(cout), W'(1));
    apply(16'h3C96, ~16'h3C96, 1'b0, "allprop cin0 R3");
    check_val("allprop cin0 sum R3", sum, '1);
    check_val("allprop cin0 cout R3", W'(cout), '0);

    // R4: top-bit generate and delete make cout independent of cin
    for (int c = 0; c < 2; c++) begin
      apply(16'h8000, 16'h8000, 1'(c), "topgen R4");
      check_val("topgen cout R4", W'(cout), W'(1));
      apply(16'h0FFF, 16'h0001, 1'(c), "topdel R4");
      check_val("topdel cout R4", W'(cout), '0);
    end

    // R5: carry born in group 0 crosses three bypassed groups
    apply(16'hA5AF, 16'h5A51, 1'b0, "chain R5");
    check_val("chain sum R5", sum, '0);
    check_val("chain cout R5", W'(cout), W'(1));

    // R1 R2 R8: random operands
    for (int n = 0; n < 300; n++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule